// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block is a bus-slave register file that runs a two-wire station management interface (MDC clock and MDIO data) toward PHY devices. Software sets a clause-select bit, a port/device address, and a 16-bit data word. It then writes the command register with a start bit and a two-bit access code. The block builds one complete management frame, shifts it out on MDIO against a divided MDC, and, for read frames, shifts in the 16 bits that the PHY returns.

Both frame families are supported. With the clause bit clear, the access code selects a read or a write of a register number. With the clause bit set, the same code field selects an address, write or read cycle toward a device number. This means a clause-45 read is an address command followed by a separate read command. A busy flag covers the whole frame. Software polls it before it issues the next command or reads the result.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register reads 0, the busy flag is 0, MDC is low, MDIO output enable is low and MDIO output idles at 1.
- R2: Register readback: offset 0x40 bit 8 is the clause select (0 = clause 22, 1 = clause 45); offset 0x44 holds the port address in bits [12:8] and the register/device number in bits [4:0]; offset 0x48 holds write data in bits [15:0]; offset 0x4C is read data in bits [15:0].
- R3: A clause-22 read (code 0) sends 32 ones, start 01, opcode 10, port, register, and then releases MDIO (output enable low) for the 2 turnaround bits and the 16 data bits.
- R4: A clause-22 write (code 1) sends 32 ones, start 01, opcode 01, port, register, turnaround 10 and the 16-bit write data, MSB first, with MDIO driven for all 64 bits.
- R5: A clause-45 address cycle (code 0) sends start 00, opcode 00, port, device, turnaround 10 and the write-data register as the register address.
- R6: A clause-45 write cycle (code 1) sends start 00, opcode 01, port, device, turnaround 10 and the write-data register.
- R7: A clause-45 read cycle (code 2) sends start 00, opcode 11, port and device, releases MDIO for turnaround and data, and the 16 bits sampled MSB first appear at offset 0x4C no later than the cycle in which busy reads 0.
- R8: Writing offset 0x50 with bit 8 set and a legal code sets busy (bit 31 of 0x50) from the next clock. Busy clears when the 64th MDC period ends.
- R9: Each MDC period lasts 2*HALF_DIV system clocks. MDIO output changes only while MDC is low, and input is sampled on the MDC rising edge.
- R10: A start written while busy is ignored: no extra frame is sent and the current frame is not altered.
- R11: Undefined codes (2 or 3 in clause-22 mode, 3 in clause-45 mode) start no frame.
- R12: A write to offset 0x50 with bit 8 clear starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | AW | Byte offset of the register |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational on addr_i) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
A scoreboard compares each frame, bit by bit, against a frame computed from the programmed fields. It checks both the driven bits and the output-enable mask. A design with swapped start codes or opcodes between the clauses, or one that drives the bus during a read turnaround, fails on that frame. A second start issued mid-frame with different fields must leave exactly one frame on the wire; a design that restarts or reloads would produce a corrupt or extra frame. Undefined codes and writes without the start bit must produce no frame and no busy. The returned read value is checked as soon as busy clears, which catches a read-data register updated one cycle late or sampled on the wrong MDC edge.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned TA_IDX     = 46;
  localparam int unsigned DATA_IDX   = 48;

  localparam logic [7:0] OFS_MODE = 8'h40;
  localparam logic [7:0] OFS_ADDR = 8'h44;
  localparam logic [7:0] OFS_WDAT = 8'h48;
  localparam logic [7:0] OFS_RDAT = 8'h4C;
  localparam logic [7:0] OFS_CMD  = 8'h50;

  localparam int unsigned CLAUSE_BIT = 8;
  localparam int unsigned START_BIT  = 8;
  localparam int unsigned BUSY_BIT   = 31;

  localparam logic [1:0] C22_RD   = 2'd0;
  localparam logic [1:0] C22_WR   = 2'd1;
  localparam logic [1:0] C45_ADR  = 2'd0;
  localparam logic [1:0] C45_WR   = 2'd1;
  localparam logic [1:0] C45_RD   = 2'd2;

  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  port;
    logic [4:0]  target;
    logic [1:0]  ta;
    logic [15:0] payload;
  } mdio_hdr_t;
endpackage

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_master_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          busy_i,
  input  logic          rx_valid_i,
  input  logic [15:0]   rx_data_i,
  output logic          c45_o,
  output logic [4:0]    port_o,
  output logic [4:0]    target_o,
  output logic [15:0]   wdat_o,
  output logic          cmd_go_o,
  output logic [1:0]    cmd_code_o
);
  logic        c45_q;
  logic [4:0]  port_q, target_q;
  logic [15:0] wdat_q, rdat_q;
  logic [1:0]  code_q;
  logic        wr;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c45_q    <= 1'b0;
      port_q   <= '0;
      target_q <= '0;
      wdat_q   <= '0;
      code_q   <= '0;
    end else if (wr) begin
      if (addr_i == AW'(OFS_MODE)) c45_q <= wdata_i[CLAUSE_BIT];
      if (addr_i == AW'(OFS_ADDR)) begin
        port_q   <= wdata_i[12:8];
        target_q <= wdata_i[4:0];
      end
      if (addr_i == AW'(OFS_WDAT)) wdat_q <= wdata_i[15:0];
      if (addr_i == AW'(OFS_CMD) && wdata_i[START_BIT] && !busy_i) code_q <= wdata_i[1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rdat_q <= '0;
    else if (rx_valid_i) rdat_q <= rx_data_i;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(OFS_MODE): rdata_o[CLAUSE_BIT] = c45_q;
      AW'(OFS_ADDR): begin
        rdata_o[12:8] = port_q;
        rdata_o[4:0]  = target_q;
      end
      AW'(OFS_WDAT): rdata_o[15:0] = wdat_q;
      AW'(OFS_RDAT): rdata_o[15:0] = rdat_q;
      AW'(OFS_CMD): begin
        rdata_o[BUSY_BIT] = busy_i;
        rdata_o[1:0]      = code_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign c45_o      = c45_q;
  assign port_o     = port_q;
  assign target_o   = target_q;
  assign wdat_o     = wdat_q;
  assign cmd_go_o   = wr && addr_i == AW'(OFS_CMD) && wdata_i[START_BIT];
  assign cmd_code_o = wdata_i[1:0];
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_master_pkg::*;
(
  input  logic        c45_i,
  input  logic [1:0]  code_i,
  input  logic [4:0]  port_i,
  input  logic [4:0]  target_i,
  input  logic [15:0] wdat_i,
  output mdio_hdr_t   hdr_o,
  output logic        rd_o,
  output logic        legal_o
);
  always_comb begin
    hdr_o.port    = port_i;
    hdr_o.target  = target_i;
    hdr_o.payload = wdat_i;
    hdr_o.ta      = 2'b10;
    hdr_o.st      = c45_i ? 2'b00 : 2'b01;
    hdr_o.op      = 2'b00;
    rd_o          = 1'b0;
    legal_o       = 1'b1;
    if (c45_i) begin
      unique case (code_i)
        C45_ADR: hdr_o.op = 2'b00;
        C45_WR:  hdr_o.op = 2'b01;
        C45_RD: begin
          hdr_o.op = 2'b11;
          rd_o     = 1'b1;
        end
        default: legal_o = 1'b0;
      endcase
    end else begin
      unique case (code_i)
        C22_RD: begin
          hdr_o.op = 2'b10;
          rd_o     = 1'b1;
        end
        C22_WR:  hdr_o.op = 2'b01;
        default: legal_o = 1'b0;
      endcase
    end
    if (rd_o) begin
      hdr_o.ta      = 2'b00;
      hdr_o.payload = '0;
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_master_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        launch_i,
  input  mdio_hdr_t   hdr_i,
  input  logic        rd_i,
  input  logic        mdio_i,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        busy_o,
  output logic        rx_valid_o,
  output logic [15:0] rx_data_o
);
  localparam int unsigned IW = $clog2(FRAME_BITS);

  logic                  busy_q, mdc_q, rd_q, tick, last;
  logic [IW-1:0]         idx_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [15:0]           rx_q;

  generate
    if (HALF_DIV <= 1) begin : g_nodiv
      assign tick = busy_q;
    end else begin : g_div
      localparam int unsigned CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (!busy_q || tick) cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
      end
      assign tick = busy_q && (cnt_q == CW'(HALF_DIV - 1));
    end
  endgenerate

  assign last = (idx_q == IW'(FRAME_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mdc_q  <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else if (launch_i && !busy_q) begin
      busy_q <= 1'b1;
      mdc_q  <= 1'b0;
      rd_q   <= rd_i;
      idx_q  <= '0;
      sh_q   <= {{PRE_BITS{1'b1}}, hdr_i};
    end else if (tick) begin
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        if (rd_q && idx_q >= IW'(DATA_IDX)) rx_q <= {rx_q[14:0], mdio_i};
      end else begin
        mdc_q <= 1'b0;
        sh_q  <= sh_q << 1;
        if (last) busy_q <= 1'b0;
        else      idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign mdc_o      = mdc_q;
  assign mdio_o     = busy_q ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o  = busy_q && !(rd_q && idx_q >= IW'(TA_IDX));
  assign busy_o     = busy_q;
  assign rx_valid_o = tick && mdc_q && last && rd_q;
  assign rx_data_o  = rx_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_master_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          mdc_o,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic          mdio_i
);
  logic        busy, rx_valid, c45, cmd_go, rd, legal, launch;
  logic [15:0] rx_data, wdat;
  logic [4:0]  port, target;
  logic [1:0]  code;
  mdio_hdr_t   hdr;

  mdio_reg_file #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .c45_o(c45), .port_o(port), .target_o(target), .wdat_o(wdat),
    .cmd_go_o(cmd_go), .cmd_code_o(code)
  );

  mdio_frame_build u_build (
    .c45_i(c45), .code_i(code), .port_i(port), .target_i(target),
    .wdat_i(wdat), .hdr_o(hdr), .rd_o(rd), .legal_o(legal)
  );

  assign launch = cmd_go && legal && !busy;

  mdio_frame_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i, .rst_ni, .launch_i(launch), .hdr_i(hdr), .rd_i(rd),
    .mdio_i, .mdc_o, .mdio_o, .mdio_oe_o, .busy_o(busy),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk
  import mdio_master_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [31:0]   wdata_i,
  input logic [31:0]   rdata_o,
  input logic          mdc_o,
  input logic          mdio_o,
  input logic          mdio_oe_o,
  input logic          busy
);
  p_busy_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(req_i && we_i && addr_i == AW'(OFS_CMD) && wdata_i[START_BIT]));

  p_idle_mdc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);

  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdio_oe_o);

  p_hold_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> $stable(mdio_o));

  p_rdata_update_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(OFS_RDAT) && $past(addr_i) == AW'(OFS_RDAT) && !$stable(rdata_o)) |-> $fell(busy));

  p_no_start_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(OFS_CMD) && !wdata_i[START_BIT] && !busy) |=> !busy);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
  .mdio_oe_o(mdio_oe_o), .busy(busy)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  localparam int HALF_DIV = 4;

  logic        clk_i = 0, rst_ni = 0, req_i = 0, we_i = 0, mdio_i;
  logic [7:0]  addr_i = 0;
  logic [31:0] wdata_i = 0, rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;

  int checks = 0, fails = 0, frames = 0, bit_n = 0, cyc = 0, last_rise = 0;
  logic [15:0]  rsp = 16'h0;
  logic [63:0]  cap_b, cap_o;
  logic [127:0] exp_q[$];

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  mdio_mgmt_master #(.AW(8), .HALF_DIV(HALF_DIV)) dut (.*);

  assign mdio_i = (bit_n >= 48) ? rsp[63 - bit_n] : 1'b1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] port,
                            input logic [4:0] tgt, input logic [15:0] data, input logic rd);
    logic [63:0] b, o;
    b = {32'hFFFF_FFFF, st, op, port, tgt, rd ? 2'b00 : 2'b10, rd ? 16'h0 : data};
    o = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    exp_q.push_back({b, o});
  endtask

  // monitor: collect one frame per 64 MDC rises and score it
  always @(posedge mdc_o) begin
    cap_b[63 - bit_n] = mdio_o;
    cap_o[63 - bit_n] = mdio_oe_o;
    if (bit_n == 1) chk("R9 mdc period", 64'(cyc - last_rise), 64'(2 * HALF_DIV));
    last_rise = cyc;
    if (bit_n == 63) begin
      bit_n = 0;
      frames++;
      if (exp_q.size() == 0) chk("R10 unexpected frame", 64'd1, 64'd0);
      else begin
        logic [127:0] e;
        e = exp_q.pop_front();
        chk("R3-R6 frame oe", cap_o, e[63:0]);
        chk("R3-R6 frame bits", cap_b & e[63:0], e[127:64] & e[63:0]);
      end
    end else bit_n = bit_n + 1;
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 4000; i++) begin
      bus_rd(8'h50, d);
      if (!d[31]) return;
    end
    chk("R8 busy never clears", 64'd1, 64'd0);
  endtask

  initial begin
    logic [31:0] d;
    int f0;
    fork
      begin
        repeat (150000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk_i);
    // R1 reset state
    bus_rd(8'h50, d); chk("R1 cmd", 64'(d), 0);
    bus_rd(8'h40, d); chk("R1 mode", 64'(d), 0);
    bus_rd(8'h4C, d); chk("R1 rdata", 64'(d), 0);
    chk("R1 pins", {61'd0, mdc_o, mdio_oe_o, mdio_o}, 64'd1);
    rst_ni = 1;
    // R2 readback
    bus_wr(8'h40, 32'h0000_0100); bus_rd(8'h40, d); chk("R2 mode", 64'(d), 64'h100);
    bus_wr(8'h44, 32'hFFFF_FAE5); bus_rd(8'h44, d); chk("R2 addr", 64'(d), 64'h1A05);
    bus_wr(8'h48, 32'h1234_BEEF); bus_rd(8'h48, d); chk("R2 wdata", 64'(d), 64'hBEEF);
    // R4 clause-22 write, R8 busy
    bus_wr(8'h40, 0);
    bus_wr(8'h44, 32'h0311);
    bus_wr(8'h48, 32'hA55A);
    push_frame(2'b01, 2'b01, 5'h03, 5'h11, 16'hA55A, 0);
    bus_wr(8'h50, 32'h101);
    bus_rd(8'h50, d); chk("R8 busy set", 64'(d[31]), 1);
    wait_idle();
    // R3 clause-22 read
    rsp = 16'h1234;
    bus_wr(8'h44, 32'h1C0A);
    push_frame(2'b01, 2'b10, 5'h1C, 5'h0A, 0, 1);
    bus_wr(8'h50, 32'h100);
    wait_idle();
    bus_rd(8'h4C, d); chk("R3 read data", 64'(d), 64'h1234);
    // R10 start while busy ignored
    rsp = 16'h0F0F;
    f0 = frames;
    push_frame(2'b01, 2'b10, 5'h1C, 5'h0A, 0, 1);
    bus_wr(8'h50, 32'h100);
    repeat (20) @(negedge clk_i);
    bus_wr(8'h44, 32'h0101);
    bus_wr(8'h50, 32'h101);
    wait_idle();
    repeat (40) @(negedge clk_i);
    chk("R10 one frame", 64'(frames - f0), 1);
    bus_rd(8'h4C, d); chk("R10 read data", 64'(d), 64'h0F0F);
    // R5 R6 R7 clause-45 sequence
    bus_wr(8'h40, 32'h100);
    bus_wr(8'h44, 32'h0703);
    bus_wr(8'h48, 32'h0040);
    push_frame(2'b00, 2'b00, 5'h07, 5'h03, 16'h0040, 0);
    bus_wr(8'h50, 32'h100); wait_idle();
    bus_wr(8'h48, 32'h5566);
    push_frame(2'b00, 2'b01, 5'h07, 5'h03, 16'h5566, 0);
    bus_wr(8'h50, 32'h101); wait_idle();
    rsp = 16'hC3A1;
    push_frame(2'b00, 2'b11, 5'h07, 5'h03, 0, 1);
    bus_wr(8'h50, 32'h102); wait_idle();
    bus_rd(8'h4C, d); chk("R7 read data", 64'(d), 64'hC3A1);
    // R11 undefined codes
    f0 = frames;
    bus_wr(8'h50, 32'h103);
    bus_rd(8'h50, d); chk("R11 c45 code3 busy", 64'(d[31]), 0);
    bus_wr(8'h40, 0);
    bus_wr(8'h50, 32'h102);
    bus_rd(8'h50, d); chk("R11 c22 code2 busy", 64'(d[31]), 0);
    // R12 no start bit
    bus_wr(8'h50, 32'h001);
    bus_rd(8'h50, d); chk("R12 busy", 64'(d[31]), 0);
    repeat (600) @(negedge clk_i);
    chk("R11 R12 no frames", 64'(frames - f0), 0);
    chk("R10 queue drained", 64'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule